// File: doc/BRIEF.md
# CAN Error Flag and Cause Capture

This block collects the error reporting of a CAN controller into one small register bank. A protocol engine gives it single-cycle event pulses: bus lock, overload frame, receive overrun, bus-off recovery, bus-off entry, error passive, error warning and bus error. The engine also gives a vector of detailed bus-error causes. The block latches the events into sticky flags and the causes into a cause register. An enable register chooses which flags can raise the shared error interrupt, and an interrupt-enable bit gates that interrupt onto the pin.

Software reads and clears the bank through one byte-wide port. A flag or a cause bit is cleared by writing 0 to it; writing 1 leaves it as it is, so one bit can be cleared without a read-modify-write race. The top bit of the cause register picks the capture mode. In one mode causes build up over time; in the other only the most recent set is kept. The engine also loads its transmit and receive error counts into the block, and software reads them back here.

Top module: `can_err_capture`

## Requirements
- R1: After reset, every readable location returns 0 and `irq_o` is low.
- R2: Flag register (address 0) bit layout, from bit 7 down to bit 0: bus lock, overload, receive overrun, bus-off recovery, bus-off entry, error passive, error warning, bus error. A pulse on `evt_i[k]` sets flag bit k on the next clock edge. A flag bit never becomes set without its event.
- R3: A write to address 0 clears every flag bit where the written data is 0 and leaves every bit where it is 1 unchanged.
- R4: When an event and a write-0 clear hit the same flag bit in the same cycle, the bit stays set.
- R5: Flag-enable register (address 1) has the same bit layout as the flags. A write stores all 8 bits, and they read back unchanged.
- R6: Interrupt status (address 4) bit 5 is 1 when any flag bit is set together with its enable bit; all other status bits read 0. Interrupt-enable (address 3) stores only bit 5; all other bits read 0. `irq_o` equals status bit 5 AND interrupt-enable bit 5.
- R7: Cause register (address 2), bits 6 down to 0: ACK delimiter error, dominant bit error, recessive bit error, CRC error, ACK error, form error, stuff error. Bit 7 is the mode bit. When the stored mode is 1, a nonzero `cause_i` is ORed into the stored causes.
- R8: When the stored mode bit is 0, a nonzero `cause_i` replaces all stored cause bits with `cause_i` in the same edge, and any clear written in that cycle has no effect.
- R9: A write to address 2 loads bit 7 directly and clears cause bits 6..0 where the data is 0. In mode 1, a cause arriving in the same cycle still sets its bit.
- R10: When `cnt_ld` is high, the block captures `tec_i` and `rec_i`. They read back at address 5 (transmit) and address 6 (receive) from the next edge on.
- R11: Writes to addresses 4 to 7 change nothing. Address 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | Single-cycle error event pulses, flag bit layout |
| cause_i | input | 7 | Bus-error cause pulses, cause bit layout |
| wr_en | input | 1 | Write strobe for the register at `addr_i` |
| addr_i | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data |
| cnt_ld | input | 1 | Load strobe for the error counters |
| tec_i | input | 8 | Transmit error count from the engine |
| rec_i | input | 8 | Receive error count from the engine |
| rd_data | output | 8 | Read data for `addr_i`, combinational from state |
| irq_o | output | 1 | Aggregate error interrupt |

## Verification
Every stored result (flags, enables, causes, mode bit, interrupt enable, counters) changes on the first rising edge that samples the stimulus. `rd_data` and `irq_o` are decoded straight from that state, so they are due right after that same edge. The bench drives all inputs on the falling edge and advances its own model at the rising edge. Just after that edge it returns the inputs to idle and reads all eight addresses and the interrupt pin. Because idle inputs cannot change the state, these reads may run across later edges without moving the expected values.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

    localparam int EVT_W_DEF   = 8;
    localparam int CAUSE_W_DEF = 7;
    localparam int CNT_W_DEF   = 8;
    localparam int DATA_W_DEF  = 8;
    localparam int ADDR_W_DEF  = 3;
    localparam int IRQ_BIT_DEF = 5;

    typedef enum logic [2:0] {
        A_FLAG  = 3'd0,
        A_FEN   = 3'd1,
        A_CAUSE = 3'd2,
        A_IEN   = 3'd3,
        A_ISTAT = 3'd4,
        A_TXCNT = 3'd5,
        A_RXCNT = 3'd6,
        A_NONE  = 3'd7
    } reg_addr_e;

endpackage

// File: rtl/can_err_flag_bank.sv
module can_err_flag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_we,
    input  logic [N-1:0] clr_data,
    input  logic         en_we,
    input  logic [N-1:0] en_data,
    output logic [N-1:0] flag_q,
    output logic [N-1:0] en_q,
    output logic         hit
);

    typedef struct packed {
        logic [N-1:0] flag;
        logic [N-1:0] en;
    } bank_t;

    bank_t        st_d, st_q;
    logic [N-1:0] flag_nx;

    // Per bit: event has priority over a write-0 clear
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic kill;
        assign kill       = clr_we & ~clr_data[i];
        assign flag_nx[i] = evt[i] | (st_q.flag[i] & ~kill);
    end

    always_comb begin
        st_d      = st_q;
        st_d.flag = flag_nx;
        if (en_we) begin
            st_d.en = en_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_q = st_q.flag;
    assign en_q   = st_q.en;
    assign hit    = |(st_q.flag & st_q.en);

endmodule

// File: rtl/can_err_cause_reg.sv
module can_err_cause_reg #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cause_i,
    input  logic         we,
    input  logic [N:0]   wdata,
    output logic [N-1:0] cause_q,
    output logic         mode_q
);

    typedef struct packed {
        logic         mode;
        logic [N-1:0] bits;
    } cause_t;

    cause_t       st_d, st_q;
    logic [N-1:0] kept;
    logic         fresh;

    always_comb begin
        st_d  = st_q;
        kept  = st_q.bits;
        fresh = |cause_i;
        if (we) begin
            kept      = st_q.bits & wdata[N-1:0];
            st_d.mode = wdata[N];
        end
        if (fresh && !st_q.mode) begin
            // latest-only: new set replaces everything
            st_d.bits = cause_i;
        end else begin
            st_d.bits = kept | cause_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_q = st_q.bits;
    assign mode_q  = st_q.mode;

endmodule

// File: rtl/can_err_readmux.sv
module can_err_readmux
    import can_err_pkg::*;
#(
    parameter int EVT_W   = 8,
    parameter int CAUSE_W = 7,
    parameter int CNT_W   = 8,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 3,
    parameter int IRQ_BIT = 5
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [EVT_W-1:0]   flag,
    input  logic [EVT_W-1:0]   fen,
    input  logic [CAUSE_W-1:0] cause,
    input  logic               cmode,
    input  logic               ien,
    input  logic               istat,
    input  logic [CNT_W-1:0]   tec,
    input  logic [CNT_W-1:0]   rec,
    output logic [DATA_W-1:0]  rd_data
);

    always_comb begin
        rd_data = '0;
        case (addr)
            A_FLAG:  rd_data = DATA_W'(flag);
            A_FEN:   rd_data = DATA_W'(fen);
            A_CAUSE: rd_data = DATA_W'({cmode, cause});
            A_IEN:   rd_data[IRQ_BIT] = ien;
            A_ISTAT: rd_data[IRQ_BIT] = istat;
            A_TXCNT: rd_data = DATA_W'(tec);
            A_RXCNT: rd_data = DATA_W'(rec);
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/can_err_capture.sv
module can_err_capture
    import can_err_pkg::*;
#(
    parameter int EVT_W   = EVT_W_DEF,
    parameter int CAUSE_W = CAUSE_W_DEF,
    parameter int CNT_W   = CNT_W_DEF,
    parameter int DATA_W  = DATA_W_DEF,
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int IRQ_BIT = IRQ_BIT_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EVT_W-1:0]   evt_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               cnt_ld,
    input  logic [CNT_W-1:0]   tec_i,
    input  logic [CNT_W-1:0]   rec_i,
    output logic [DATA_W-1:0]  rd_data,
    output logic               irq_o
);

    typedef struct packed {
        logic             ien;
        logic [CNT_W-1:0] tec;
        logic [CNT_W-1:0] rec;
    } top_t;

    top_t               st_d, st_q;
    logic               flag_we, fen_we, cause_we, ien_we;
    logic [EVT_W-1:0]   flag_vec, fen_vec;
    logic [CAUSE_W-1:0] cause_vec;
    logic               cmode;
    logic               istat;

    assign flag_we  = wr_en && (addr_i == A_FLAG);
    assign fen_we   = wr_en && (addr_i == A_FEN);
    assign cause_we = wr_en && (addr_i == A_CAUSE);
    assign ien_we   = wr_en && (addr_i == A_IEN);

    can_err_flag_bank #(.N(EVT_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_i),
        .clr_we   (flag_we),
        .clr_data (wr_data[EVT_W-1:0]),
        .en_we    (fen_we),
        .en_data  (wr_data[EVT_W-1:0]),
        .flag_q   (flag_vec),
        .en_q     (fen_vec),
        .hit      (istat)
    );

    can_err_cause_reg #(.N(CAUSE_W)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (cause_i),
        .we      (cause_we),
        .wdata   (wr_data[CAUSE_W:0]),
        .cause_q (cause_vec),
        .mode_q  (cmode)
    );

    always_comb begin
        st_d = st_q;
        if (ien_we) begin
            st_d.ien = wr_data[IRQ_BIT];
        end
        if (cnt_ld) begin
            st_d.tec = tec_i;
            st_d.rec = rec_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    can_err_readmux #(
        .EVT_W   (EVT_W),
        .CAUSE_W (CAUSE_W),
        .CNT_W   (CNT_W),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .IRQ_BIT (IRQ_BIT)
    ) u_rd (
        .addr    (addr_i),
        .flag    (flag_vec),
        .fen     (fen_vec),
        .cause   (cause_vec),
        .cmode   (cmode),
        .ien     (st_q.ien),
        .istat   (istat),
        .tec     (st_q.tec),
        .rec     (st_q.rec),
        .rd_data (rd_data)
    );

    assign irq_o = istat & st_q.ien;

endmodule

// File: rtl/can_err_checker.sv
module can_err_checker
    import can_err_pkg::*;
#(
    parameter int EVT_W   = 8,
    parameter int CAUSE_W = 7,
    parameter int CNT_W   = 8,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [EVT_W-1:0]   evt_i,
    input logic [CAUSE_W-1:0] cause_i,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [DATA_W-1:0]  wr_data,
    input logic               cnt_ld,
    input logic [CNT_W-1:0]   tec_i,
    input logic [CNT_W-1:0]   rec_i,
    input logic               irq_o,
    input logic [EVT_W-1:0]   flags,
    input logic [EVT_W-1:0]   fen,
    input logic [CAUSE_W-1:0] causes,
    input logic               cmode,
    input logic               ien,
    input logic [CNT_W-1:0]   tec_q,
    input logic [CNT_W-1:0]   rec_q
);

    logic flag_wr;
    assign flag_wr = wr_en && (addr_i == A_FLAG);

    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((flags & $past(evt_i)) == $past(evt_i)));

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((flags & ~$past(flags) & ~$past(evt_i)) == '0));

    p_one_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |=> ((flags & $past(flags & wr_data[EVT_W-1:0]))
                     == $past(flags & wr_data[EVT_W-1:0])));

    p_zero_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |=> ((flags & $past(~wr_data[EVT_W-1:0] & ~evt_i)) == '0));

    p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ien && ((flags & fen) != '0)));

    p_accumulate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_i != '0) && cmode) |=> ((causes & $past(cause_i)) == $past(cause_i)));

    p_latest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_i != '0) && !cmode) |=> (causes == $past(cause_i)));

    p_counter_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_ld |=> ((tec_q == $past(tec_i)) && (rec_q == $past(rec_i))));

endmodule

bind can_err_capture can_err_checker #(
    .EVT_W   (EVT_W),
    .CAUSE_W (CAUSE_W),
    .CNT_W   (CNT_W),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .cause_i (cause_i),
    .wr_en   (wr_en),
    .addr_i  (addr_i),
    .wr_data (wr_data),
    .cnt_ld  (cnt_ld),
    .tec_i   (tec_i),
    .rec_i   (rec_i),
    .irq_o   (irq_o),
    .flags   (flag_vec),
    .fen     (fen_vec),
    .causes  (cause_vec),
    .cmode   (cmode),
    .ien     (st_q.ien),
    .tec_q   (st_q.tec),
    .rec_q   (st_q.rec)
);

// File: tb/can_err_capture_bench.sv
module can_err_capture_bench;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_i = '0;
    logic [6:0] cause_i = '0;
    logic       wr_en = 1'b0;
    logic [2:0] addr_i = '0;
    logic [7:0] wr_data = '0;
    logic       cnt_ld = 1'b0;
    logic [7:0] tec_i = '0;
    logic [7:0] rec_i = '0;
    logic [7:0] rd_data;
    logic       irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model
    logic [7:0] m_flag, m_fen, m_tec, m_rec;
    logic [6:0] m_cause;
    logic       m_mode, m_ien;

    can_err_capture u_can_err_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .cause_i (cause_i),
        .wr_en   (wr_en),
        .addr_i  (addr_i),
        .wr_data (wr_data),
        .cnt_ld  (cnt_ld),
        .tec_i   (tec_i),
        .rec_i   (rec_i),
        .rd_data (rd_data),
        .irq_o   (irq_o)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic exp_istat();
        return |(m_flag & m_fen);
    endfunction

    function automatic logic [7:0] exp_read(int a);
        case (a)
            0: return m_flag;
            1: return m_fen;
            2: return {m_mode, m_cause};
            3: return {2'b00, m_ien, 5'b0};
            4: return {2'b00, exp_istat(), 5'b0};
            5: return m_tec;
            6: return m_rec;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string req_of(int a);
        case (a)
            0: return "R2/R3/R4";
            1: return "R5";
            2: return "R7/R8/R9";
            3: return "R6";
            4: return "R6";
            5: return "R10";
            6: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_flag = '0; m_fen = '0; m_cause = '0; m_mode = 1'b0;
        m_ien = 1'b0; m_tec = '0; m_rec = '0;
    endtask

    // next state from the requirements, using the inputs of this cycle
    task automatic model_step();
        logic [6:0] kept;
        logic       wf, we, wc, wi;
        wf = wr_en && addr_i == 3'd0;
        we = wr_en && addr_i == 3'd1;
        wc = wr_en && addr_i == 3'd2;
        wi = wr_en && addr_i == 3'd3;
        kept = wc ? (m_cause & wr_data[6:0]) : m_cause;
        if (cause_i != 0 && !m_mode) kept = cause_i;      // R8
        else kept = kept | cause_i;                       // R7 R9
        m_cause = kept;
        if (wc) m_mode = wr_data[7];
        m_flag = (wf ? (m_flag & wr_data) : m_flag) | evt_i;  // R3 R4
        if (we) m_fen = wr_data;
        if (wi) m_ien = wr_data[5];
        if (cnt_ld) begin m_tec = tec_i; m_rec = rec_i; end
    endtask

    task automatic idle();
        evt_i = '0; cause_i = '0; wr_en = 1'b0; wr_data = '0;
        cnt_ld = 1'b0; tec_i = '0; rec_i = '0;
    endtask

    task automatic check_all();
        for (int a = 0; a < 8; a++) begin
            addr_i = 3'(a);
            #1;
            chk(req_of(a), rd_data, exp_read(a));
        end
        chk("R6 irq", {7'b0, irq_o}, {7'b0, exp_istat() & m_ien});
    endtask

    task automatic step(logic [7:0] e, logic [6:0] c, logic w, logic [2:0] a,
                        logic [7:0] d, logic ld, logic [7:0] t, logic [7:0] r);
        @(negedge clk);
        evt_i = e; cause_i = c; wr_en = w; addr_i = a; wr_data = d;
        cnt_ld = ld; tec_i = t; rec_i = r;
        @(posedge clk);
        model_step();
        #1;
        idle();
        check_all();
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check_all();                                   // R1 while in reset
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check_all();                                   // R1 after release

        // R2: each event alone sets its own bit
        for (int k = 0; k < 8; k++) step(8'(1 << k), '0, 0, 0, 0, 0, 0, 0);
        // R3: clear odd bits, keep even
        step('0, '0, 1, 3'd0, 8'h55, 0, 0, 0);
        // R4: event and clear on the same bit
        step(8'h01, '0, 1, 3'd0, 8'h00, 0, 0, 0);
        // R5/R6: enable, then interrupt enable
        step('0, '0, 1, 3'd1, 8'h01, 0, 0, 0);
        step('0, '0, 1, 3'd3, 8'hFF, 0, 0, 0);
        step('0, '0, 1, 3'd0, 8'h00, 0, 0, 0);         // R6 irq drops
        // R8: latest-only replaces
        step('0, 7'h05, 0, 0, 0, 0, 0, 0);
        step('0, 7'h40, 0, 0, 0, 0, 0, 0);
        step('0, 7'h02, 1, 3'd2, 8'h00, 0, 0, 0);      // R8 clear ignored
        // R7: accumulate mode
        step('0, '0, 1, 3'd2, 8'hFF, 0, 0, 0);
        step('0, 7'h01, 0, 0, 0, 0, 0, 0);
        step('0, 7'h10, 0, 0, 0, 0, 0, 0);
        // R9: clear with a concurrent cause
        step('0, 7'h04, 1, 3'd2, 8'h80, 0, 0, 0);
        // R10: counters
        step('0, '0, 0, 0, 0, 1, 8'hA5, 8'h3C);
        step('0, '0, 0, 0, 0, 1, 8'hFF, 8'h00);
        // R11: writes to read-only addresses
        for (int a = 4; a < 8; a++) step('0, '0, 1, 3'(a), 8'h00, 0, 0, 0);

        // random phase
        for (int n = 0; n < 400; n++) begin
            logic [7:0] e, d, t, r;
            logic [6:0] c;
            logic       w, ld;
            logic [2:0] a;
            e  = 8'($urandom & $urandom & $urandom);
            c  = 7'($urandom & $urandom & $urandom);
            w  = ($urandom % 10) < 3;
            a  = 3'($urandom);
            d  = 8'($urandom | $urandom);
            ld = ($urandom % 10) == 0;
            t  = 8'($urandom);
            r  = 8'($urandom);
            step(e, c, w, a, d, ld, t, r);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule